// File: doc/BRIEF.md
# Macro-op Fusion Pair Detector

This decode-stage unit receives the two oldest instructions from a fetch buffer each cycle. Each arrives already expanded to its 32-bit form, with a flag that says whether it was fetched as a 16-bit compressed encoding. The unit compares the pair with three fixed idioms: an indexed load, a zero-extend of the low word, and a shift-and-add address computation. Each idiom carries its own register-dependency conditions. On a hit it issues a single macro-op with merged operand fields. That macro-op fills one downstream slot, and the unit reports that two input slots were consumed. On a miss it issues only the first instruction as an ordinary op and reports one consumed slot.

Each issued op also carries the byte advance for the program counter: the sum of both lengths for a fused pair, the first instruction's length otherwise. Both sides of the unit use a valid/ready handshake, with one output register. A fusion-inhibit input makes every pair go out unfused, which lets a pair that faulted be replayed as two separate ops. Each idiom can be removed at elaboration time with a parameter.

Top module: `mof_pair_fuser`

## Requirements
- R1: When slot 0 holds ADD rd,ra,rb (opcode 0110011, funct3 000, funct7 0) and slot 1 holds LD rd,0(rd) (opcode 0000011, funct3 011, immediate 0) with the same rd, the unit emits one op with fused=1, kind=1 (indexed load), rd=rd, rs1=ra, rs2=rb and shift 0. A non-zero load offset or a register mismatch prevents fusion.
- R2: When slot 0 holds SLLI rd,rs,32 and slot 1 holds SRLI rd,rd,32 (opcode 0010011, funct3 001 and 101, bits 31:26 zero, shift in bits 25:20), the unit emits fused=1, kind=2 (zero-extend word), rd=rd, rs1=rs, rs2=0, shift 32. Any other shift amount prevents fusion.
- R3: When slot 0 holds SLLI rd,ra,sh (any sh) and slot 1 holds ADD rd,rd,rb with rb different from rd, the unit emits fused=1, kind=3 (shift-add), rd=rd, rs1=ra, rs2=rb, shift=sh. If rb equals rd the pair is not fused.
- R4: A fused op reports a byte advance of 4, 6 or 8 (the sum of 2 for each compressed and 4 for each standard instruction) and a consumed count of 2.
- R5: An unmatched pair emits fused=0, kind=0, the first instruction unchanged, rd/rs1/rs2 taken from its bits 11:7, 19:15, 24:20, shift 0, an advance equal to its own length, and a consumed count of 1.
- R6: While the fusion-inhibit input is high when a pair is accepted, the op is unfused, as in R5.
- R7: When slot 1 is not valid, no fusion is attempted and the op is as in R5.
- R8: A pair whose first instruction writes x0 is never fused.
- R9: The input is accepted when slot 0 is valid and input-ready is high. Input-ready equals (no op held) or output-ready. A held op keeps all of its fields stable while output-ready is low.
- R10: After reset the output holds no op (output-valid low) and input-ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nofuse_i | input | 1 | Fusion inhibit used for replay |
| in_valid0_i | input | 1 | Slot 0 holds an instruction |
| in_insn0_i | input | 32 | Slot 0 instruction, expanded form |
| in_cmp0_i | input | 1 | Slot 0 was a 16-bit encoding |
| in_valid1_i | input | 1 | Slot 1 holds an instruction |
| in_insn1_i | input | 32 | Slot 1 instruction, expanded form |
| in_cmp1_i | input | 1 | Slot 1 was a 16-bit encoding |
| in_pc_i | input | PC_W | Address of slot 0 |
| in_ready_o | output | 1 | Unit can take a pair this cycle |
| out_valid_o | output | 1 | An op is held at the output |
| out_ready_i | input | 1 | Downstream takes the held op |
| out_fused_o | output | 1 | Op is a fused macro-op |
| out_kind_o | output | 2 | 0 none, 1 indexed load, 2 zero-extend, 3 shift-add |
| out_rd_o | output | 5 | Destination register |
| out_rs1_o | output | 5 | First source register |
| out_rs2_o | output | 5 | Second source register |
| out_shamt_o | output | 6 | Shift amount of the macro-op |
| out_pc_o | output | PC_W | Address of the first instruction |
| out_insn_o | output | 32 | First instruction as received |
| out_advance_o | output | 4 | Byte advance for the program counter |
| out_consumed_o | output | 2 | Input slots consumed (1 or 2) |

## Verification
The bench aims at near misses in the register conditions. One is a shift-add whose ADD reads the shifted register twice: a design that skips that check fuses it and reads a stale value. Others are a load with a non-zero offset and a shift of 31 before a right shift of 32. The bench also covers x0 destinations, a missing second slot and replay mode, in which a careless design would still fuse and over-advance the program counter. Every mix of the two length flags is driven to catch a wrong advance of 6. Random backpressure catches outputs that change or get dropped while output-ready is low.

// File: rtl/mof_pkg.sv
package mof_pkg;

   localparam int REG_W  = 5;
   localparam int SH_W   = 6;
   localparam int INSN_W = 32;

   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_OP_IMM = 7'b0010011;

   typedef enum logic [1:0] {
      MOP_NONE  = 2'd0,
      MOP_IDXLD = 2'd1,
      MOP_ZEXTW = 2'd2,
      MOP_SHADD = 2'd3
   } mop_kind_e;

   typedef struct packed {
      logic             is_add;
      logic             is_ld0;
      logic             is_slli;
      logic             is_srli;
      logic [REG_W-1:0] rd;
      logic [REG_W-1:0] rs1;
      logic [REG_W-1:0] rs2;
      logic [SH_W-1:0]  sh;
   } insn_info_t;

endpackage

// File: rtl/mof_insn_fields.sv
module mof_insn_fields
   import mof_pkg::*;
(
   input  logic [INSN_W-1:0] insn_i,
   output insn_info_t        info_o
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;

   always_comb begin
      opc = insn_i[6:0];
      f3  = insn_i[14:12];
      f7  = insn_i[31:25];
      info_o.rd      = insn_i[11:7];
      info_o.rs1     = insn_i[19:15];
      info_o.rs2     = insn_i[24:20];
      info_o.sh      = insn_i[25:20];
      info_o.is_add  = (opc == OPC_OP) && (f3 == 3'b000) && (f7 == 7'd0);
      info_o.is_ld0  = (opc == OPC_LOAD) && (f3 == 3'b011) && (insn_i[31:20] == 12'd0);
      info_o.is_slli = (opc == OPC_OP_IMM) && (f3 == 3'b001) && (insn_i[31:26] == 6'd0);
      info_o.is_srli = (opc == OPC_OP_IMM) && (f3 == 3'b101) && (insn_i[31:26] == 6'd0);
   end

endmodule

// File: rtl/mof_idiom_match.sv
module mof_idiom_match
   import mof_pkg::*;
#(
   parameter bit EN_IDXLD = 1'b1,
   parameter bit EN_ZEXTW = 1'b1,
   parameter bit EN_SHADD = 1'b1,
   parameter int ZEXT_SH  = 32
)(
   input  insn_info_t       a_i,
   input  insn_info_t       b_i,
   input  logic             allow_i,
   output mop_kind_e        kind_o,
   output logic [REG_W-1:0] rd_o,
   output logic [REG_W-1:0] rs1_o,
   output logic [REG_W-1:0] rs2_o,
   output logic [SH_W-1:0]  sh_o
);

   localparam logic [SH_W-1:0] ZSH = SH_W'(ZEXT_SH);

   logic base_ok;
   logic hit_idx, hit_zext, hit_shadd;

   assign base_ok = allow_i && (a_i.rd != '0);

   generate
      if (EN_IDXLD) begin : g_idx
         assign hit_idx = base_ok && a_i.is_add && b_i.is_ld0 &&
                          (b_i.rs1 == a_i.rd) && (b_i.rd == a_i.rd);
      end else begin : g_no_idx
         assign hit_idx = 1'b0;
      end

      if (EN_ZEXTW) begin : g_zext
         assign hit_zext = base_ok && a_i.is_slli && b_i.is_srli &&
                           (a_i.sh == ZSH) && (b_i.sh == ZSH) &&
                           (b_i.rs1 == a_i.rd) && (b_i.rd == a_i.rd);
      end else begin : g_no_zext
         assign hit_zext = 1'b0;
      end

      if (EN_SHADD) begin : g_shadd
         assign hit_shadd = base_ok && a_i.is_slli && b_i.is_add &&
                            (b_i.rs1 == a_i.rd) && (b_i.rd == a_i.rd) &&
                            (b_i.rs2 != a_i.rd);
      end else begin : g_no_shadd
         assign hit_shadd = 1'b0;
      end
   endgenerate

   always_comb begin
      kind_o = MOP_NONE;
      rd_o   = a_i.rd;
      rs1_o  = a_i.rs1;
      rs2_o  = a_i.rs2;
      sh_o   = '0;
      if (hit_idx) begin
         kind_o = MOP_IDXLD;
      end else if (hit_zext) begin
         kind_o = MOP_ZEXTW;
         rs2_o  = '0;
         sh_o   = a_i.sh;
      end else if (hit_shadd) begin
         kind_o = MOP_SHADD;
         rs2_o  = b_i.rs2;
         sh_o   = a_i.sh;
      end
   end

   // R1, R2 and R3: the idioms are mutually exclusive on their second opcode
   always_comb begin
      assert_one_idiom_R1: assert ($onehot0({hit_idx, hit_zext, hit_shadd}))
         else $error("more than one idiom matched");
   end

endmodule

// File: rtl/mof_pair_fuser.sv
module mof_pair_fuser
   import mof_pkg::*;
#(
   parameter int PC_W     = 64,
   parameter bit EN_IDXLD = 1'b1,
   parameter bit EN_ZEXTW = 1'b1,
   parameter bit EN_SHADD = 1'b1,
   parameter int ZEXT_SH  = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nofuse_i,
   input  logic              in_valid0_i,
   input  logic [31:0]       in_insn0_i,
   input  logic              in_cmp0_i,
   input  logic              in_valid1_i,
   input  logic [31:0]       in_insn1_i,
   input  logic              in_cmp1_i,
   input  logic [PC_W-1:0]   in_pc_i,
   output logic              in_ready_o,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic              out_fused_o,
   output logic [1:0]        out_kind_o,
   output logic [4:0]        out_rd_o,
   output logic [4:0]        out_rs1_o,
   output logic [4:0]        out_rs2_o,
   output logic [5:0]        out_shamt_o,
   output logic [PC_W-1:0]   out_pc_o,
   output logic [31:0]       out_insn_o,
   output logic [3:0]        out_advance_o,
   output logic [1:0]        out_consumed_o
);

   localparam int NSLOT = 2;
   localparam int ADV_W = 4;
   localparam logic [ADV_W-1:0] LEN_C = ADV_W'(2);
   localparam logic [ADV_W-1:0] LEN_S = ADV_W'(4);

   generate
      if (PC_W < 16) begin : g_bad_pc
         $error("PC_W must be at least 16");
      end
      if (ZEXT_SH <= 0 || ZEXT_SH >= (1 << SH_W)) begin : g_bad_zsh
         $error("ZEXT_SH must fit the shift field");
      end
   endgenerate

   logic [INSN_W-1:0] insn_arr [NSLOT];
   logic              cmp_arr  [NSLOT];
   insn_info_t        info     [NSLOT];
   logic [ADV_W-1:0]  len_arr  [NSLOT];

   assign insn_arr[0] = in_insn0_i;
   assign insn_arr[1] = in_insn1_i;
   assign cmp_arr[0]  = in_cmp0_i;
   assign cmp_arr[1]  = in_cmp1_i;

   generate
      for (genvar g = 0; g < NSLOT; g++) begin : g_slot
         mof_insn_fields u_fields (
            .insn_i (insn_arr[g]),
            .info_o (info[g])
         );
         assign len_arr[g] = cmp_arr[g] ? LEN_C : LEN_S;
      end
   endgenerate

   mop_kind_e        m_kind;
   logic [REG_W-1:0] m_rd, m_rs1, m_rs2;
   logic [SH_W-1:0]  m_sh;
   logic             allow;

   assign allow = in_valid1_i && !nofuse_i;

   mof_idiom_match #(
      .EN_IDXLD (EN_IDXLD),
      .EN_ZEXTW (EN_ZEXTW),
      .EN_SHADD (EN_SHADD),
      .ZEXT_SH  (ZEXT_SH)
   ) u_match (
      .a_i     (info[0]),
      .b_i     (info[1]),
      .allow_i (allow),
      .kind_o  (m_kind),
      .rd_o    (m_rd),
      .rs1_o   (m_rs1),
      .rs2_o   (m_rs2),
      .sh_o    (m_sh)
   );

   logic fuse, accept;
   assign fuse       = (m_kind != MOP_NONE);
   assign in_ready_o = !out_valid_o || out_ready_i;
   assign accept     = in_valid0_i && in_ready_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o    <= 1'b0;
         out_fused_o    <= 1'b0;
         out_kind_o     <= MOP_NONE;
         out_rd_o       <= '0;
         out_rs1_o      <= '0;
         out_rs2_o      <= '0;
         out_shamt_o    <= '0;
         out_pc_o       <= '0;
         out_insn_o     <= '0;
         out_advance_o  <= '0;
         out_consumed_o <= '0;
      end else if (accept) begin
         out_valid_o    <= 1'b1;
         out_fused_o    <= fuse;
         out_kind_o     <= m_kind;
         out_rd_o       <= m_rd;
         out_rs1_o      <= m_rs1;
         out_rs2_o      <= m_rs2;
         out_shamt_o    <= m_sh;
         out_pc_o       <= in_pc_i;
         out_insn_o     <= in_insn0_i;
         out_advance_o  <= fuse ? (len_arr[0] + len_arr[1]) : len_arr[0];
         out_consumed_o <= fuse ? 2'd2 : 2'd1;
      end else if (out_ready_i) begin
         out_valid_o    <= 1'b0;
      end
   end

   // R9: a stalled op stays put
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_insn_o) &&
       $stable(out_kind_o) && $stable(out_advance_o) && $stable(out_pc_o)))
      else $error("held op changed");

   // R6: replay mode never fuses
   assert_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && nofuse_i) |=> !out_fused_o)
      else $error("fused in replay mode");

   // R7: lone first slot never fuses
   assert_lone_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !in_valid1_i) |=> (!out_fused_o && out_consumed_o == 2'd1))
      else $error("fused without second slot");

   // R8: x0 destination never fused
   assert_no_x0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_fused_o) |-> (out_rd_o != '0))
      else $error("fused op writes x0");

   // R4: fused advance spans two instructions
   assert_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_fused_o) |-> (out_advance_o >= 4'd4 && out_advance_o <= 4'd8))
      else $error("bad fused advance");

endmodule

// File: tb/tb_mof_pair_fuser.sv
module tb_mof_pair_fuser;

   localparam int PC_W = 64;
   localparam int VW   = 1 + 2 + 5 + 5 + 5 + 6 + PC_W + 32 + 4 + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nofuse = 1'b0;
   logic v0 = 1'b0, v1 = 1'b0, c0 = 1'b0, c1 = 1'b0;
   logic [31:0] i0 = '0, i1 = '0;
   logic [PC_W-1:0] pc = '0;
   logic in_ready, out_valid, out_ready = 1'b1;
   logic out_fused;
   logic [1:0] out_kind, out_cons;
   logic [4:0] out_rd, out_rs1, out_rs2;
   logic [5:0] out_sh;
   logic [PC_W-1:0] out_pc;
   logic [31:0] out_insn;
   logic [3:0] out_adv;

   int checks = 0;
   int errors = 0;
   int ready_mode = 0;
   logic [PC_W-1:0] pc_ctr = 64'h8000_0000;

   always #5 clk = ~clk;

   mof_pair_fuser #(.PC_W(PC_W)) dut (
      .clk(clk), .rst_n(rst_n), .nofuse_i(nofuse),
      .in_valid0_i(v0), .in_insn0_i(i0), .in_cmp0_i(c0),
      .in_valid1_i(v1), .in_insn1_i(i1), .in_cmp1_i(c1),
      .in_pc_i(pc), .in_ready_o(in_ready),
      .out_valid_o(out_valid), .out_ready_i(out_ready),
      .out_fused_o(out_fused), .out_kind_o(out_kind),
      .out_rd_o(out_rd), .out_rs1_o(out_rs1), .out_rs2_o(out_rs2),
      .out_shamt_o(out_sh), .out_pc_o(out_pc), .out_insn_o(out_insn),
      .out_advance_o(out_adv), .out_consumed_o(out_cons)
   );

   function automatic logic [31:0] e_add(int rd, int ra, int rb);
      return {7'd0, 5'(rb), 5'(ra), 3'b000, 5'(rd), 7'b0110011};
   endfunction
   function automatic logic [31:0] e_sub(int rd, int ra, int rb);
      return {7'b0100000, 5'(rb), 5'(ra), 3'b000, 5'(rd), 7'b0110011};
   endfunction
   function automatic logic [31:0] e_ld(int rd, int ra, int off);
      return {12'(off), 5'(ra), 3'b011, 5'(rd), 7'b0000011};
   endfunction
   function automatic logic [31:0] e_slli(int rd, int ra, int sh);
      return {6'd0, 6'(sh), 5'(ra), 3'b001, 5'(rd), 7'b0010011};
   endfunction
   function automatic logic [31:0] e_srli(int rd, int ra, int sh);
      return {6'd0, 6'(sh), 5'(ra), 3'b101, 5'(rd), 7'b0010011};
   endfunction

   // class: 1 add, 2 ld with zero offset, 3 slli, 4 srli, 0 other
   function automatic int cls(logic [31:0] x);
      casez (x)
         32'b0000000_?????_?????_000_?????_0110011: return 1;
         32'b000000000000_?????_011_?????_0000011:  return 2;
         32'b000000_??????_?????_001_?????_0010011: return 3;
         32'b000000_??????_?????_101_?????_0010011: return 4;
         default: return 0;
      endcase
   endfunction

   logic [VW-1:0] exp_q[$];
   string         tag_q[$];

   task automatic model(input logic [31:0] a, input logic ca, input logic [31:0] b,
                        input logic cb, input logic vb, input logic nf,
                        input logic [PC_W-1:0] p);
      int ka = cls(a);
      int kb = cls(b);
      int ra_d = int'(a[11:7]);
      int ra_1 = int'(a[19:15]);
      int ra_2 = int'(a[24:20]);
      int sha  = int'(a[25:20]);
      int rb_d = int'(b[11:7]);
      int rb_1 = int'(b[19:15]);
      int rb_2 = int'(b[24:20]);
      int shb  = int'(b[25:20]);
      int la = ca ? 2 : 4;
      int lb = cb ? 2 : 4;
      int kind = 0;
      int o1 = ra_1, o2 = ra_2, osh = 0;
      string t = "R5";
      if (!vb) t = "R7";
      else if (nf) t = "R6";
      else if (ra_d == 0) t = "R8";
      else if (ka == 1 && kb == 2 && rb_1 == ra_d && rb_d == ra_d) begin
         kind = 1; t = "R1";
      end else if (ka == 3 && kb == 4 && sha == 32 && shb == 32 && rb_1 == ra_d && rb_d == ra_d) begin
         kind = 2; o2 = 0; osh = 32; t = "R2";
      end else if (ka == 3 && kb == 1 && rb_1 == ra_d && rb_d == ra_d && rb_2 != ra_d) begin
         kind = 3; o2 = rb_2; osh = sha; t = "R3";
      end
      exp_q.push_back({kind != 0, 2'(kind), 5'(ra_d), 5'(o1), 5'(o2), 6'(osh), p, a,
                       4'(kind != 0 ? la + lb : la), 2'(kind != 0 ? 2 : 1)});
      tag_q.push_back(t);
   endtask

   // reference comparison at every falling edge, then model update
   always @(negedge clk) begin
      logic [VW-1:0] got;
      got = {out_fused, out_kind, out_rd, out_rs1, out_rs2, out_sh, out_pc, out_insn, out_adv, out_cons};
      if (!rst_n) begin
         checks++;
         if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 out_valid got %b exp 0", out_valid);
         end
      end else begin
         checks++;
         if (in_ready !== (exp_q.size() == 0 || out_ready)) begin
            errors++;
            $display("FAIL R9 in_ready got %b exp %b", in_ready, (exp_q.size() == 0 || out_ready));
         end
         checks++;
         if (out_valid !== (exp_q.size() != 0)) begin
            errors++;
            $display("FAIL R9 out_valid got %b exp %b", out_valid, exp_q.size() != 0);
         end else if (out_valid) begin
            checks++;
            if (got !== exp_q[0]) begin
               errors++;
               $display("FAIL %s (fields, R4 advance, R9 hold) got %h exp %h", tag_q[0], got, exp_q[0]);
            end
         end
         if (exp_q.size() != 0 && out_ready) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
         if (v0 && in_ready) model(i0, c0, i1, c1, v1, nofuse, pc);
      end
   end

   initial begin
      forever begin
         @(posedge clk); #1;
         out_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom_range(0, 2) != 0);
      end
   end

   task automatic send(input logic [31:0] a, input logic ca, input logic [31:0] b,
                       input logic cb, input logic vb, input logic nf);
      @(posedge clk); #1;
      v0 = 1'b1; i0 = a; c0 = ca; i1 = b; c1 = cb; v1 = vb; nofuse = nf; pc = pc_ctr;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      pc_ctr = pc_ctr + 64'd6;
   endtask

   task automatic idle();
      @(posedge clk); #1;
      v0 = 1'b0; v1 = 1'b0; nofuse = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10 after reset: ready with nothing held
      @(negedge clk);
      checks++;
      if (in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R10 in_ready got %b exp 1", in_ready);
      end
      send(e_add(5, 6, 7), 0, e_ld(5, 5, 0), 0, 1, 0);     // R1, R4 advance 8
      send(e_add(9, 1, 2), 1, e_ld(9, 9, 0), 0, 1, 0);     // R1, R4 advance 6
      send(e_add(9, 1, 2), 0, e_ld(9, 9, 8), 0, 1, 0);     // R1 offset blocks
      send(e_add(9, 1, 2), 0, e_ld(9, 3, 0), 0, 1, 0);     // R1 base mismatch
      send(e_slli(4, 8, 32), 1, e_srli(4, 4, 32), 1, 1, 0); // R2, R4 advance 4
      send(e_slli(4, 8, 31), 0, e_srli(4, 4, 32), 0, 1, 0); // R2 wrong shift
      send(e_slli(3, 10, 3), 0, e_add(3, 3, 11), 1, 1, 0); // R3, advance 6
      send(e_slli(3, 10, 3), 0, e_add(3, 3, 3), 0, 1, 0);  // R3 rb equals rd
      send(e_slli(3, 10, 32), 0, e_add(3, 3, 12), 0, 1, 0); // R3 shift 32
      send(e_add(5, 6, 7), 0, e_sub(5, 5, 1), 0, 1, 0);    // R5 unmatched
      send(e_add(5, 6, 7), 0, e_ld(5, 5, 0), 0, 1, 1);     // R6 replay
      send(e_add(5, 6, 7), 1, e_ld(5, 5, 0), 0, 0, 0);     // R7 lone slot
      send(e_add(0, 6, 7), 0, e_ld(0, 0, 0), 0, 1, 0);     // R8 x0
      send(e_slli(0, 6, 32), 0, e_srli(0, 0, 32), 0, 1, 0); // R8 x0
      idle();
      // R9 backpressure with a random stream covering every idiom
      ready_mode = 1;
      for (int n = 0; n < 400; n++) begin
         int rd = $urandom_range(0, 7);
         int ra = $urandom_range(0, 7);
         int rb = $urandom_range(0, 7);
         int sel = $urandom_range(0, 4);
         logic [31:0] a, b;
         case (sel)
            0: begin a = e_add(rd, ra, rb); b = e_ld($urandom_range(0, 1) ? rd : ra, rd, $urandom_range(0, 3) == 0 ? 16 : 0); end
            1: begin a = e_slli(rd, ra, 32); b = e_srli(rd, $urandom_range(0, 3) == 0 ? ra : rd, $urandom_range(0, 3) == 0 ? 16 : 32); end
            2: begin a = e_slli(rd, ra, $urandom_range(0, 63)); b = e_add(rd, rd, rb); end
            3: begin a = e_sub(rd, ra, rb); b = e_add(rd, rd, rb); end
            default: begin a = e_add(rd, ra, rb); b = e_srli(rd, rd, 32); end
         endcase
         send(a, 1'($urandom_range(0, 1)), b, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 7) == 0));
      end
      idle();
      ready_mode = 0;
      repeat (10) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule